// File: doc/BRIEF.md
# Vectored priority interrupt controller

This block gathers eight interrupt sources for a small microcontroller core. The sources are two external pins, four timer underflow pulses, a converter-done pulse and a serial-done pulse. A pin source fires on any level change of its pin. Every source owns a sticky request flag. The flag sets whenever the source fires, whatever the enable state.

Each source also has an enable bit. The eight bits are written through two 4-bit enable registers. When the bit is 1, the source is served by a vectored interrupt. When the bit is 0, the core polls the source with a skip test, and a true test consumes the flag. A global enable, set by an EI strobe and cleared by a DI strobe, gates all interrupts. The global enable also drops by itself when the core accepts an interrupt.

Among the sources that are both enabled and flagged, the controller picks the one with the highest fixed priority. It raises a request together with that source's vector address. The core's acknowledge, given in the same cycle, clears the chosen flag and the global enable.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all request flags, all enable bits and the global enable are 0, so `irq_o`, `skip_o` and `req_o` are all 0.
- R2: A source event sets its flag in `req_o` at the next clock edge, even with the enable bit or the global enable at 0. The flag then holds until an accept or a skip clears it. The bits of `req_o` are: bit 0 pin 0, bit 1 pin 1, bits 2 to 5 timers 1 to 4 (`tmr_uf_i[0..3]`), bit 6 converter, bit 7 serial.
- R3: Any level change of `ext_pin_i[k]` between two clock edges sets flag k at the second edge. Both directions count.
- R4: `irq_o` is 1 exactly when the global enable is 1 and at least one source has both its flag and its enable bit set. `irq_vec_o` then equals 0x80 + 2*i, where i is the lowest such bit index. Bit 0 has the highest priority.
- R5: An `ack_i` that comes while `irq_o` is 1 clears the served flag and the global enable at the next edge. The other flags are kept.
- R6: The global enable is set by `ei_i` and cleared by `di_i`. When `ei_i` comes in the same cycle as `di_i` or as an accepted acknowledge, the enable ends up cleared.
- R7: A write with `en_wr_i`=1 loads `en_wdata_i[3:0]` into enable bits 3..0 when `en_sel_i`=0, and into enable bits 7..4 when `en_sel_i`=1.
- R8: `skip_o` is 1 exactly when `skip_req_i` is 1, the flag selected by `skip_sel_i` is set, and that source's enable bit is 0. A 1 on `skip_o` clears that flag at the next edge. When the enable bit is 1, the skip test reads 0 and leaves the flag unchanged.
- R9: When a source event arrives in the same cycle as a clear of that source's flag (by accept or by skip), the flag stays set.
- R10: An `ack_i` while `irq_o` is 0 changes neither the flags nor the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 2 | External pin levels; a change fires the source |
| tmr_uf_i | input | 4 | Timer 1..4 underflow pulses |
| adc_done_i | input | 1 | Converter completion pulse |
| sio_done_i | input | 1 | Serial transfer completion pulse |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| en_wr_i | input | 1 | Enable register write strobe |
| en_sel_i | input | 1 | Enable register select (0: sources 0-3, 1: sources 4-7) |
| en_wdata_i | input | 4 | Enable register write data |
| skip_req_i | input | 1 | Skip test query |
| skip_sel_i | input | 3 | Source index under test |
| ack_i | input | 1 | Core accepts the current request |
| irq_o | output | 1 | Interrupt request |
| irq_vec_o | output | 13 | Vector address of the chosen source |
| skip_o | output | 1 | Skip test result |
| req_o | output | 8 | Request flags |

## Verification
The bench targets several corner cases.
- Several flags pending when EI arrives: a wrong priority encoder would return the vector of a lower-priority source.
- EI together with DI, and EI together with an acknowledge: if the set won, the request would be raised again at once.
- A source event in the same cycle as an accept, or as a skip clear, of the same flag: if the clear won, the new event would be lost.
- A skip test on an enabled source, and an acknowledge with no request pending: a careless design would skip, or would drop a flag or the global enable.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned NUM_EXT    = 2;
  localparam int unsigned NUM_TMR    = 4;
  localparam int unsigned NUM_SRC    = NUM_EXT + NUM_TMR + 2;
  localparam int unsigned EN_REG_W   = 4;
  localparam int unsigned NUM_EN_REG = NUM_SRC / EN_REG_W;
  localparam int unsigned SRC_IDX_W  = $clog2(NUM_SRC);
  localparam int unsigned EN_SEL_W   = (NUM_EN_REG > 1) ? $clog2(NUM_EN_REG) : 1;
endpackage

// File: rtl/vic_edge_det.sv
module vic_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] pin_q;

  for (genvar k = 0; k < W; k++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q[k] <= 1'b0;
      else         pin_q[k] <= pin_i[k];
    end
    assign chg_o[k] = pin_i[k] ^ pin_q[k];
  end
endmodule

// File: rtl/vic_req_flags.sv
module vic_req_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set wins over clear so a coincident event is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[i] <= 1'b0;
      else if (set_i[i])  flag_o[i] <= 1'b1;
      else if (clr_i[i])  flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int unsigned N        = 8,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned VEC_BASE = 128,
  parameter int unsigned STRIDE   = 2
) (
  input  logic [N-1:0]      req_i,
  output logic              valid_o,
  output logic [N-1:0]      onehot_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx = IDX_W'(i);
    end
  end

  assign valid_o  = |req_i;
  assign onehot_o = valid_o ? (N'(1) << idx) : '0;
  assign vec_o    = ADDR_W'(VEC_BASE) + ADDR_W'(idx) * ADDR_W'(STRIDE);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned PAGE_WORDS = 128,
  parameter int unsigned VEC_PAGE   = 1,
  parameter int unsigned VEC_STRIDE = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EXT-1:0]   ext_pin_i,
  input  logic [NUM_TMR-1:0]   tmr_uf_i,
  input  logic                 adc_done_i,
  input  logic                 sio_done_i,
  input  logic                 ei_i,
  input  logic                 di_i,
  input  logic                 en_wr_i,
  input  logic [EN_SEL_W-1:0]  en_sel_i,
  input  logic [EN_REG_W-1:0]  en_wdata_i,
  input  logic                 skip_req_i,
  input  logic [SRC_IDX_W-1:0] skip_sel_i,
  input  logic                 ack_i,
  output logic                 irq_o,
  output logic [ADDR_W-1:0]    irq_vec_o,
  output logic                 skip_o,
  output logic [NUM_SRC-1:0]   req_o
);
  localparam int unsigned VEC_BASE = VEC_PAGE * PAGE_WORDS;

  logic [NUM_EXT-1:0] pin_chg;
  logic [NUM_SRC-1:0] src_evt, en_q, pend, win_oh, skip_oh, flag_clr;
  logic               pend_any, gie_q, accept;

  vic_edge_det #(.W(NUM_EXT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .chg_o  (pin_chg)
  );

  assign src_evt = {sio_done_i, adc_done_i, tmr_uf_i, pin_chg};

  for (genvar r = 0; r < NUM_EN_REG; r++) begin : g_en_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        en_q[r*EN_REG_W +: EN_REG_W] <= '0;
      else if (en_wr_i && (en_sel_i == EN_SEL_W'(r)))
        en_q[r*EN_REG_W +: EN_REG_W] <= en_wdata_i;
    end
  end

  assign pend = req_o & en_q;

  vic_prio_enc #(
    .N        (NUM_SRC),
    .IDX_W    (SRC_IDX_W),
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE),
    .STRIDE   (VEC_STRIDE)
  ) u_prio (
    .req_i    (pend),
    .valid_o  (pend_any),
    .onehot_o (win_oh),
    .vec_o    (irq_vec_o)
  );

  assign irq_o  = gie_q & pend_any;
  assign accept = irq_o & ack_i;

  // skip valid only while the source is in polled mode
  assign skip_o  = skip_req_i & req_o[skip_sel_i] & ~en_q[skip_sel_i];
  assign skip_oh = skip_o ? (NUM_SRC'(1) << skip_sel_i) : '0;

  assign flag_clr = (accept ? win_oh : '0) | skip_oh;

  vic_req_flags #(.N(NUM_SRC)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (src_evt),
    .clr_i  (flag_clr),
    .flag_o (req_o)
  );

  // clear beats set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              gie_q <= 1'b0;
    else if (di_i || accept)  gie_q <= 1'b0;
    else if (ei_i)            gie_q <= 1'b1;
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int unsigned ADDR_W   = 13,
  parameter int unsigned VEC_BASE = 128
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_EXT-1:0]   ext_pin_i,
  input logic [NUM_TMR-1:0]   tmr_uf_i,
  input logic                 adc_done_i,
  input logic                 sio_done_i,
  input logic                 ack_i,
  input logic [SRC_IDX_W-1:0] skip_sel_i,
  input logic                 irq_o,
  input logic [ADDR_W-1:0]    irq_vec_o,
  input logic                 skip_o,
  input logic [NUM_SRC-1:0]   req_o
);
  logic [NUM_EXT-1:0]   pin_q;
  logic [NUM_SRC-1:0]   evt, evt_q;
  logic [SRC_IDX_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= '0;
      evt_q <= '0;
      sel_q <= '0;
    end else begin
      pin_q <= ext_pin_i;
      evt_q <= evt;
      sel_q <= skip_sel_i;
    end
  end

  assign evt = {sio_done_i, adc_done_i, tmr_uf_i, ext_pin_i ^ pin_q};

  a_r2_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((req_o & evt_q) == evt_q));

  a_r4_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|req_o));

  a_r4_vec_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!irq_vec_o[0] && irq_vec_o >= ADDR_W'(VEC_BASE)
               && irq_vec_o <= ADDR_W'(VEC_BASE + 2 * (NUM_SRC - 1))));

  a_r5_ack_ends_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> !irq_o);

  a_r8_skip_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> (!req_o[sel_q] || evt_q[sel_q]));

  a_r10_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !skip_o && !(|evt)) |=> (req_o == $past(req_o)));
endmodule

bind vec_irq_ctrl vic_checker #(
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_PAGE * PAGE_WORDS)
) u_vic_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ext_pin_i  (ext_pin_i),
  .tmr_uf_i   (tmr_uf_i),
  .adc_done_i (adc_done_i),
  .sio_done_i (sio_done_i),
  .ack_i      (ack_i),
  .skip_sel_i (skip_sel_i),
  .irq_o      (irq_o),
  .irq_vec_o  (irq_vec_o),
  .skip_o     (skip_o),
  .req_o      (req_o)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_pin = '0;
  logic [3:0] tmr_uf = '0;
  logic       adc_done = 1'b0, sio_done = 1'b0, ei = 1'b0, di = 1'b0;
  logic       en_wr = 1'b0, en_sel = 1'b0, skip_req = 1'b0, ack = 1'b0;
  logic [3:0] en_wdata = '0;
  logic [2:0] skip_sel = '0;
  logic        irq, skip;
  logic [12:0] irq_vec;
  logic [7:0]  req;

  logic [7:0] m_flag = '0, m_en = '0;
  logic       m_gie = 1'b0;
  logic [1:0] m_pin_q = '0;
  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .tmr_uf_i(tmr_uf),
    .adc_done_i(adc_done), .sio_done_i(sio_done), .ei_i(ei), .di_i(di),
    .en_wr_i(en_wr), .en_sel_i(en_sel), .en_wdata_i(en_wdata),
    .skip_req_i(skip_req), .skip_sel_i(skip_sel), .ack_i(ack),
    .irq_o(irq), .irq_vec_o(irq_vec), .skip_o(skip), .req_o(req)
  );

  function automatic int low_idx(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) if (p[i]) low_idx = i;
  endfunction

  function automatic logic exp_irq();
    return m_gie && ((m_flag & m_en) != 0);
  endfunction

  function automatic logic exp_skip();
    return skip_req && m_flag[skip_sel] && !m_en[skip_sel];
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    tmr_uf = '0; adc_done = 0; sio_done = 0; ei = 0; di = 0;
    en_wr = 0; skip_req = 0; ack = 0;
  endtask

  // inputs already driven after a falling edge
  task automatic cycle(input string tag);
    logic [7:0] evt, clr;
    logic       e_irq, e_skip;
    int         idx;
    #1;
    e_irq  = exp_irq();
    e_skip = exp_skip();
    idx    = low_idx(m_flag & m_en);
    chk(tag, "irq_o", int'(irq), int'(e_irq));
    if (e_irq) chk(tag, "irq_vec_o", int'(irq_vec), 128 + 2 * idx);
    chk(tag, "skip_o", int'(skip), int'(e_skip));
    chk(tag, "req_o", int'(req), int'(m_flag));
    @(posedge clk);
    evt = {sio_done, adc_done, tmr_uf, ext_pin ^ m_pin_q};
    clr = '0;
    if (e_irq && ack) clr[idx] = 1'b1;
    if (e_skip) clr[skip_sel] = 1'b1;
    m_flag = evt | (m_flag & ~clr);
    if (di || (e_irq && ack)) m_gie = 1'b0;
    else if (ei)              m_gie = 1'b1;
    if (en_wr) begin
      if (en_sel) m_en[7:4] = en_wdata;
      else        m_en[3:0] = en_wdata;
    end
    m_pin_q = ext_pin;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle(); cycle("R1");
    // R2 flag sets with everything disabled
    tmr_uf = 4'b0001; cycle("R2"); idle(); cycle("R2");
    // R8 skip on polled source consumes flag
    skip_req = 1; skip_sel = 3'd2; cycle("R8"); idle(); cycle("R8");
    // R3 level change on pin 1, both directions
    ext_pin = 2'b10; cycle("R3"); idle(); cycle("R3");
    ext_pin = 2'b00; cycle("R3"); cycle("R3");
    // R7 enable register 0 bit 1 -> source 1; skip then invalid
    en_wr = 1; en_sel = 0; en_wdata = 4'b0010; cycle("R7"); idle();
    skip_req = 1; skip_sel = 3'd1; cycle("R8"); idle(); cycle("R7");
    // R6 EI and DI together leave global enable cleared
    ei = 1; di = 1; cycle("R6"); idle(); cycle("R6");
    ei = 1; cycle("R6"); idle(); cycle("R4");
    // R7 register 1 bit 1 -> source 5, plus timer 4 event
    en_wr = 1; en_sel = 1; en_wdata = 4'b0010; tmr_uf = 4'b1000; cycle("R7");
    idle(); cycle("R4");
    // R5 accept clears served flag and global enable
    ack = 1; ei = 1; cycle("R5"); idle(); cycle("R5");
    ei = 1; cycle("R6"); idle(); cycle("R4");
    // R9 event coinciding with accept keeps flag
    ack = 1; tmr_uf = 4'b1000; cycle("R9"); idle(); cycle("R9");
    // R10 ack with no request
    ack = 1; cycle("R10"); idle(); cycle("R10");
    // R9 event coinciding with skip keeps flag
    sio_done = 1; cycle("R9"); idle();
    skip_req = 1; skip_sel = 3'd7; sio_done = 1; cycle("R9"); idle(); cycle("R9");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom % 6 == 0) tmr_uf = 4'($urandom);
      adc_done = ($urandom % 9 == 0);
      sio_done = ($urandom % 9 == 0);
      if ($urandom % 7 == 0) ext_pin = 2'($urandom);
      ei = ($urandom % 4 == 0);
      di = ($urandom % 11 == 0);
      if ($urandom % 10 == 0) begin
        en_wr = 1; en_sel = 1'($urandom); en_wdata = 4'($urandom);
      end
      skip_req = ($urandom % 3 == 0);
      skip_sel = 3'($urandom);
      ack = exp_irq() ? ($urandom % 2 == 0) : ($urandom % 8 == 0);
      cycle("R4");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule